// File: doc/BRIEF.md
# Indirect Bus-Cycle Access Port

This block gives a local CPU a small set of registers through which it can start single bus cycles on an external parallel bus. Software first places the target address in the address register. It then writes a command byte, which holds a command code and active-low byte enables. For reads, the command write itself starts the cycle. For writes, the cycle starts only when software stores the data word. The port holds one request toward a bus-master model until that model reports the cycle done, with or without a master abort.

A read result is captured into the read-data register. Disabled byte lanes are cleared in that result. A master abort replaces the result with all ones and sets a sticky status flag, which software clears by writing 1 to it. Three further error inputs set their own sticky flags. An enable register selects which flags drive the interrupt output. While a cycle is outstanding, any CPU access is stalled with a wait signal until the cycle finishes.

Top module: `xbus_cycle_port`

## Requirements
- R1: After reset the address, command, write-data, read-data, status and enable registers read 0, `bus_req` is low and `irq` is low.
- R2: Register offsets: address 0x00, command 0x04 (bits 7:0 kept), write data 0x08, read data 0x0C, status 0x20 (bits 3:0), enable 0x24 (bits 3:0). The address, command, write-data and enable registers read back what was written. A write to 0x0C has no effect.
- R3: A command write whose code in bits 3:0 is a read code (0x2 I/O read, 0x6 memory read, 0xA config read) launches a read cycle. A command write with any other code launches nothing.
- R4: A write-data write launches a write cycle when the stored command code is a write code (0x3 I/O write, 0x7 memory write, 0xB config write). Otherwise it only stores the data.
- R5: A launched cycle presents the command code, the active-low byte enables from command bits 7:4 (bit i controls byte lane i, bits 8i+7:8i) and the address register. `bus_req` and these fields stay stable until `bus_done`.
- R6: On a write cycle, byte lanes whose enable bit is 1 are driven as 0 on `bus_wdata`.
- R7: A read cycle that completes without abort stores `bus_rdata` in the read-data register, with disabled lanes cleared to 0.
- R8: A cycle that ends with `bus_abort` sets status bit 1. If it was a read, the read-data register becomes all ones.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. A set event in the same cycle as the clear wins.
- R10: The inputs `err_sys`, `err_par` and `err_loc` set status bits 0, 2 and 3 respectively.
- R11: `irq` is high exactly when some status bit and its enable bit (same position) are both 1.
- R12: While a cycle is outstanding, every CPU access is held with `cpu_wait` high and takes effect only after the cycle has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Register byte offset |
| cpu_wr | input | 1 | CPU write request |
| cpu_rd | input | 1 | CPU read request |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (valid in the accepting cycle) |
| cpu_wait | output | 1 | Access held; retry next cycle |
| err_sys | input | 1 | System-error event |
| err_par | input | 1 | Parity-error event |
| err_loc | input | 1 | Local-bus error event |
| bus_req | output | 1 | Cycle outstanding toward bus master |
| bus_cmd | output | 4 | Command code of the cycle |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_addr | output | 32 | Cycle address |
| bus_wdata | output | 32 | Lane-masked write data |
| bus_done | input | 1 | Cycle finished (one-cycle pulse) |
| bus_abort | input | 1 | Cycle ended in master abort (with done) |
| bus_rdata | input | 32 | Read data (with done) |
| irq | output | 1 | Interrupt output |

## Verification
Two situations are hardest to reach from the ports. The first is a CPU access that arrives while a cycle is still in flight. The bench creates it by giving the bus model a long response latency and then writing the address register at once. It confirms that the wait was seen, that the outstanding cycle kept its old address, and that the new address landed afterwards. The second is an error event that coincides with a write-1-to-clear of the same status bit. The bench produces it by raising the error input in the very cycle the clearing write is accepted.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_DW    = 32;
    localparam int XB_LANES = XB_DW / 8;
    localparam int XB_OFF_W = 8;
    localparam int XB_NSTAT = 4;

    localparam logic [XB_OFF_W-1:0] OFF_ADDR = 8'h00;
    localparam logic [XB_OFF_W-1:0] OFF_CMD  = 8'h04;
    localparam logic [XB_OFF_W-1:0] OFF_WDAT = 8'h08;
    localparam logic [XB_OFF_W-1:0] OFF_RDAT = 8'h0C;
    localparam logic [XB_OFF_W-1:0] OFF_STAT = 8'h20;
    localparam logic [XB_OFF_W-1:0] OFF_IEN  = 8'h24;

    typedef enum logic [3:0] {
        CMD_IO_RD  = 4'h2,
        CMD_IO_WR  = 4'h3,
        CMD_MEM_RD = 4'h6,
        CMD_MEM_WR = 4'h7,
        CMD_CFG_RD = 4'hA,
        CMD_CFG_WR = 4'hB
    } xb_cmd_e;

    typedef struct packed {
        logic [3:0]          cmd;
        logic [XB_LANES-1:0] be_n;
        logic [XB_DW-1:0]    addr;
        logic [XB_DW-1:0]    wdata;
    } xb_req_t;

    typedef struct packed {
        logic loc_err;
        logic par_err;
        logic mabort;
        logic sys_err;
    } xb_stat_t;

    function automatic logic is_read_cmd(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_MEM_RD) || (c == CMD_CFG_RD);
    endfunction

    function automatic logic is_write_cmd(input logic [3:0] c);
        return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_CFG_WR);
    endfunction

    function automatic logic [XB_DW-1:0] lane_mask(input logic [XB_LANES-1:0] be_n);
        logic [XB_DW-1:0] m;
        for (int i = 0; i < XB_LANES; i++) begin
            m[i*8 +: 8] = {8{~be_n[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/xbus_launch_ctl.sv
module xbus_launch_ctl
    import xbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_we,
    input  logic                cmd_we,
    input  logic                wdat_we,
    input  logic [XB_DW-1:0]    wr_data,
    output logic                busy_o,
    output logic [XB_DW-1:0]    addr_o,
    output logic [7:0]          cmd_o,
    output logic [XB_DW-1:0]    wdat_o,
    output logic [XB_DW-1:0]    rdat_o,
    output xb_req_t             req_o,
    input  logic                bus_done,
    input  logic                bus_abort,
    input  logic [XB_DW-1:0]    bus_rdata,
    output logic                abort_evt_o
);

    logic            busy_q;
    logic            rd_cyc_q;
    logic [XB_DW-1:0] addr_q, wdat_q, rdat_q;
    logic [7:0]      cmd_q;
    xb_req_t         req_q;
    logic            launch_rd, launch_wr, finish;

    assign launch_rd   = cmd_we  && is_read_cmd(wr_data[3:0]);
    assign launch_wr   = wdat_we && is_write_cmd(cmd_q[3:0]);
    assign finish      = busy_q && bus_done;
    assign abort_evt_o = finish && bus_abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            rd_cyc_q <= 1'b0;
            addr_q   <= '0;
            cmd_q    <= '0;
            wdat_q   <= '0;
            rdat_q   <= '0;
            req_q    <= '0;
        end else begin
            if (addr_we) addr_q <= wr_data;
            if (cmd_we)  cmd_q  <= wr_data[7:0];
            if (wdat_we) wdat_q <= wr_data;

            if (launch_rd) begin
                busy_q     <= 1'b1;
                rd_cyc_q   <= 1'b1;
                req_q.cmd  <= wr_data[3:0];
                req_q.be_n <= wr_data[7:4];
                req_q.addr <= addr_q;
                req_q.wdata <= '0;
            end else if (launch_wr) begin
                busy_q     <= 1'b1;
                rd_cyc_q   <= 1'b0;
                req_q.cmd  <= cmd_q[3:0];
                req_q.be_n <= cmd_q[7:4];
                req_q.addr <= addr_q;
                req_q.wdata <= wr_data & lane_mask(cmd_q[7:4]);
            end else if (finish) begin
                busy_q <= 1'b0;
                if (bus_abort) begin
                    if (rd_cyc_q) rdat_q <= '1;
                end else if (rd_cyc_q) begin
                    rdat_q <= bus_rdata & lane_mask(req_q.be_n);
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign addr_o = addr_q;
    assign cmd_o  = cmd_q;
    assign wdat_o = wdat_q;
    assign rdat_o = rdat_q;
    assign req_o  = req_q;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy_q && !bus_done |=> busy_q && $stable(req_q)); // R5
    AST_ABORT_ONES: assert property (@(posedge clk) disable iff (rst)
        busy_q && bus_done && bus_abort && rd_cyc_q |=> rdat_q == '1); // R8
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (addr_we || cmd_we || wdat_we) |-> !busy_q); // R12
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
        busy_q && bus_done |=> !busy_q); // R12

endmodule

// File: rtl/xbus_status_unit.sv
module xbus_status_unit
    import xbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  xb_stat_t            set_evt,
    input  logic                clr_we,
    input  logic [XB_NSTAT-1:0] clr_bits,
    input  logic                ien_we,
    input  logic [XB_NSTAT-1:0] ien_data,
    output logic [XB_NSTAT-1:0] stat_o,
    output logic [XB_NSTAT-1:0] ien_o,
    output logic                irq_o
);

    logic [XB_NSTAT-1:0] stat_q, ien_q, clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | set_evt;
            if (ien_we) ien_q <= ien_data;
        end
    end

    assign stat_o = stat_q;
    assign ien_o  = ien_q;
    assign irq_o  = |(stat_q & ien_q);

    AST_ABORT_LATCH: assert property (@(posedge clk) disable iff (rst)
        set_evt.mabort |=> stat_q[1]); // R8
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_we && clr_bits[1] && !set_evt.mabort |=> !stat_q[1]); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat_q[3] && !(clr_we && clr_bits[3]) |=> stat_q[3]); // R9

endmodule

// File: rtl/xbus_cycle_port.sv
module xbus_cycle_port
    import xbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [XB_OFF_W-1:0] cpu_addr,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [XB_DW-1:0]    cpu_wdata,
    output logic [XB_DW-1:0]    cpu_rdata,
    output logic                cpu_wait,
    input  logic                err_sys,
    input  logic                err_par,
    input  logic                err_loc,
    output logic                bus_req,
    output logic [3:0]          bus_cmd,
    output logic [XB_LANES-1:0] bus_be_n,
    output logic [XB_DW-1:0]    bus_addr,
    output logic [XB_DW-1:0]    bus_wdata,
    input  logic                bus_done,
    input  logic                bus_abort,
    input  logic [XB_DW-1:0]    bus_rdata,
    output logic                irq
);

    logic                busy;
    logic                wr_ok;
    logic [XB_DW-1:0]    addr_r, wdat_r, rdat_r;
    logic [7:0]          cmd_r;
    logic [XB_NSTAT-1:0] stat_r, ien_r;
    logic                abort_evt;
    xb_req_t             req;
    xb_stat_t            set_evt;

    assign cpu_wait = busy && (cpu_wr || cpu_rd);
    assign wr_ok    = cpu_wr && !busy;

    assign set_evt = '{loc_err: err_loc, par_err: err_par,
                       mabort: abort_evt, sys_err: err_sys};

    xbus_launch_ctl u_launch (
        .clk        (clk),
        .rst        (rst),
        .addr_we    (wr_ok && cpu_addr == OFF_ADDR),
        .cmd_we     (wr_ok && cpu_addr == OFF_CMD),
        .wdat_we    (wr_ok && cpu_addr == OFF_WDAT),
        .wr_data    (cpu_wdata),
        .busy_o     (busy),
        .addr_o     (addr_r),
        .cmd_o      (cmd_r),
        .wdat_o     (wdat_r),
        .rdat_o     (rdat_r),
        .req_o      (req),
        .bus_done   (bus_done),
        .bus_abort  (bus_abort),
        .bus_rdata  (bus_rdata),
        .abort_evt_o(abort_evt)
    );

    xbus_status_unit u_status (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (set_evt),
        .clr_we   (wr_ok && cpu_addr == OFF_STAT),
        .clr_bits (cpu_wdata[XB_NSTAT-1:0]),
        .ien_we   (wr_ok && cpu_addr == OFF_IEN),
        .ien_data (cpu_wdata[XB_NSTAT-1:0]),
        .stat_o   (stat_r),
        .ien_o    (ien_r),
        .irq_o    (irq)
    );

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            OFF_ADDR: cpu_rdata = addr_r;
            OFF_CMD:  cpu_rdata = {{(XB_DW-8){1'b0}}, cmd_r};
            OFF_WDAT: cpu_rdata = wdat_r;
            OFF_RDAT: cpu_rdata = rdat_r;
            OFF_STAT: cpu_rdata = {{(XB_DW-XB_NSTAT){1'b0}}, stat_r};
            OFF_IEN:  cpu_rdata = {{(XB_DW-XB_NSTAT){1'b0}}, ien_r};
            default:  cpu_rdata = '0;
        endcase
    end

    assign bus_req   = busy;
    assign bus_cmd   = req.cmd;
    assign bus_be_n  = req.be_n;
    assign bus_addr  = req.addr;
    assign bus_wdata = req.wdata;

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat_r != '0); // R11

endmodule

// File: tb/tb_xbus_cycle_port.sv
`timescale 1ns/1ps
module tb_xbus_cycle_port;
    import xbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_wait;
    logic        err_sys = 1'b0, err_par = 1'b0, err_loc = 1'b0;
    logic        bus_req;
    logic [3:0]  bus_cmd, bus_be_n;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_done = 1'b0, bus_abort = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        irq;

    int tests = 0, fails = 0;
    logic [71:0] exp_q[$];
    int          rsp_lat = 3;
    logic        rsp_abort_v = 1'b0;
    logic [31:0] rsp_data_v = '0;
    logic        saw_wait;
    logic [31:0] rv;

    always #2 clk = ~clk;

    xbus_cycle_port dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        saw_wait = 1'b0;
        #1;
        while (cpu_wait) begin saw_wait = 1'b1; @(negedge clk); #1; end
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        while (cpu_wait) begin @(negedge clk); #1; end
        d = cpu_rdata;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    task automatic expect_req(input logic [3:0] c, input logic [3:0] be, input logic [31:0] a, input logic [31:0] w);
        exp_q.push_back({c, be, a, w});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (bus_req) @(negedge clk);
    endtask

    // Monitor and bus model: pops expected requests, compares, then answers
    initial begin
        forever begin
            @(posedge clk); #1;
            if (bus_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R4 unexpected cycle", {28'd0, bus_cmd}, 32'd0);
                end else begin
                    logic [71:0] e;
                    e = exp_q.pop_front();
                    chk(bus_cmd == e[71:68], "R5 cmd", {28'd0, bus_cmd}, {28'd0, e[71:68]});
                    chk(bus_be_n == e[67:64], "R5 be_n", {28'd0, bus_be_n}, {28'd0, e[67:64]});
                    chk(bus_addr == e[63:32], "R5 addr", bus_addr, e[63:32]);
                    chk(bus_wdata == e[31:0], "R6 wdata", bus_wdata, e[31:0]);
                end
                repeat (rsp_lat - 1) @(posedge clk);
                #1;
                bus_done = 1'b1; bus_abort = rsp_abort_v; bus_rdata = rsp_data_v;
                @(posedge clk); #1;
                bus_done = 1'b0; bus_abort = 1'b0; bus_rdata = '0;
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(bus_req == 0, "R1 bus_req", {31'd0, bus_req}, 0);
        chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
        cpu_read(OFF_ADDR, rv); chk(rv == 0, "R1 addr", rv, 0);
        cpu_read(OFF_RDAT, rv); chk(rv == 0, "R1 rdat", rv, 0);
        cpu_read(OFF_STAT, rv); chk(rv == 0, "R1 stat", rv, 0);

        // R3/R7 config read, full lanes
        rsp_data_v = 32'hCAFEF00D; rsp_abort_v = 0;
        cpu_write(OFF_ADDR, 32'h0000_0810);
        cpu_read(OFF_ADDR, rv); chk(rv == 32'h0000_0810, "R2 addr readback", rv, 32'h810);
        expect_req(4'hA, 4'h0, 32'h0000_0810, 0);
        cpu_write(OFF_CMD, 32'h0A);
        chk(bus_req == 1, "R3 read launched by cmd", {31'd0, bus_req}, 1);
        wait_idle();
        cpu_read(OFF_RDAT, rv); chk(rv == 32'hCAFEF00D, "R7 read data", rv, 32'hCAFEF00D);

        // R7 partial lanes: be_n=1100 keeps lanes 0,1
        expect_req(4'h6, 4'hC, 32'h0000_0810, 0);
        cpu_write(OFF_CMD, 32'hC6);
        wait_idle();
        cpu_read(OFF_RDAT, rv); chk(rv == 32'h0000F00D, "R7 lane mask", rv, 32'h0000F00D);
        cpu_read(OFF_CMD, rv); chk(rv == 32'hC6, "R2 cmd readback", rv, 32'hC6);

        // R4 write cycle: cmd write does not launch, data write does
        cpu_write(OFF_ADDR, 32'h0000_0A00);
        cpu_write(OFF_CMD, 32'h0B);
        chk(bus_req == 0, "R4 cmd write no launch", {31'd0, bus_req}, 0);
        expect_req(4'hB, 4'h0, 32'h0000_0A00, 32'h12345678);
        cpu_write(OFF_WDAT, 32'h12345678);
        chk(bus_req == 1, "R4 write launched by data", {31'd0, bus_req}, 1);
        wait_idle();

        // R6 write lane masking: be_n=0101 drops lanes 0,2
        cpu_write(OFF_CMD, 32'h57);
        expect_req(4'h7, 4'h5, 32'h0000_0A00, 32'hAA00CC00);
        cpu_write(OFF_WDAT, 32'hAABBCCDD);
        wait_idle();
        cpu_read(OFF_WDAT, rv); chk(rv == 32'hAABBCCDD, "R2 wdat readback", rv, 32'hAABBCCDD);

        // R8 master abort on read
        rsp_abort_v = 1;
        expect_req(4'h2, 4'h0, 32'h0000_0A00, 0);
        cpu_write(OFF_CMD, 32'h02);
        wait_idle();
        rsp_abort_v = 0;
        cpu_read(OFF_RDAT, rv); chk(rv == 32'hFFFFFFFF, "R8 all ones", rv, 32'hFFFFFFFF);
        cpu_read(OFF_STAT, rv); chk(rv == 32'h2, "R8 abort flag", rv, 2);
        chk(irq == 0, "R11 irq masked", {31'd0, irq}, 0);
        cpu_write(OFF_IEN, 32'h2);
        chk(irq == 1, "R11 irq enabled", {31'd0, irq}, 1);
        cpu_write(OFF_STAT, 32'h1);
        cpu_read(OFF_STAT, rv); chk(rv == 32'h2, "R9 write of other bit keeps flag", rv, 2);
        cpu_write(OFF_STAT, 32'h2);
        cpu_read(OFF_STAT, rv); chk(rv == 32'h0, "R9 w1c clears", rv, 0);
        chk(irq == 0, "R11 irq after clear", {31'd0, irq}, 0);

        // R2 read-data register ignores writes
        cpu_write(OFF_RDAT, 32'h11111111);
        cpu_read(OFF_RDAT, rv); chk(rv == 32'hFFFFFFFF, "R2 rdat write ignored", rv, 32'hFFFFFFFF);

        // R12 access during an outstanding cycle is held
        rsp_lat = 20; rsp_data_v = 32'h0BADBEEF;
        expect_req(4'hA, 4'h0, 32'h0000_0A00, 0);
        cpu_write(OFF_CMD, 32'h0A);
        cpu_write(OFF_ADDR, 32'h0000_0C00);
        chk(saw_wait == 1, "R12 wait seen", {31'd0, saw_wait}, 1);
        chk(bus_req == 0, "R12 write after cycle done", {31'd0, bus_req}, 0);
        cpu_read(OFF_ADDR, rv); chk(rv == 32'h0000_0C00, "R12 held write landed", rv, 32'hC00);
        cpu_read(OFF_RDAT, rv); chk(rv == 32'h0BADBEEF, "R12 cycle result", rv, 32'h0BADBEEF);
        rsp_lat = 3;

        // R10 error inputs, R11 enable selection
        @(negedge clk); err_par = 1; @(negedge clk); err_par = 0;
        cpu_read(OFF_STAT, rv); chk(rv == 32'h4, "R10 parity bit 2", rv, 4);
        chk(irq == 0, "R11 irq off with other enable", {31'd0, irq}, 0);
        cpu_write(OFF_IEN, 32'h4);
        chk(irq == 1, "R11 irq on parity", {31'd0, irq}, 1);
        cpu_read(OFF_IEN, rv); chk(rv == 32'h4, "R2 ien readback", rv, 4);
        @(negedge clk); err_sys = 1; err_loc = 1; @(negedge clk); err_sys = 0; err_loc = 0;
        cpu_read(OFF_STAT, rv); chk(rv == 32'hD, "R10 sys and local bits", rv, 32'hD);
        cpu_write(OFF_STAT, 32'hD);
        cpu_read(OFF_STAT, rv); chk(rv == 32'h0, "R9 clear all", rv, 0);

        // R9 set wins over simultaneous clear
        @(negedge clk);
        cpu_addr = OFF_STAT; cpu_wdata = 32'h8; cpu_wr = 1; err_loc = 1;
        @(posedge clk); #1;
        cpu_wr = 0; err_loc = 0;
        cpu_read(OFF_STAT, rv); chk(rv == 32'h8, "R9 set wins", rv, 8);

        // R3/R4 unsupported codes launch nothing
        cpu_write(OFF_CMD, 32'h05);
        chk(bus_req == 0, "R3 bad code no launch", {31'd0, bus_req}, 0);
        cpu_write(OFF_CMD, 32'h0A & 32'h08);
        cpu_write(OFF_WDAT, 32'h5555AAAA);
        chk(bus_req == 0, "R4 data write without write code", {31'd0, bus_req}, 0);
        cpu_read(OFF_WDAT, rv); chk(rv == 32'h5555AAAA, "R4 data stored", rv, 32'h5555AAAA);

        repeat (10) @(posedge clk);
        chk(exp_q.size() == 0, "R5 expected cycles all seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule